// File: doc/BRIEF.md
# USB Periodic Transaction Bus-Time Estimator

This unit works out how many bus bytes one periodic USB transaction takes up in the worst case. An admission controller uses the figure to decide whether an interrupt or isochronous endpoint still fits in a frame or microframe. Each request gives the device speed, whether the transfer is isochronous, the data direction, whether the cost is for one phase of a split transaction (and which phase), the maximum packet size, and the number of transactions per microframe.

The payload term always assumes worst-case bit stuffing, which is seven sixths of the packet size with the fraction dropped. Low-speed payloads are stretched eight times because the low-speed clock is slower. To the payload the unit adds a protocol overhead chosen by speed, type, direction and split phase, a fixed host delay and, for low speed, a hub setup cost. A request that describes no valid case raises an error flag and returns a count of zero.

The result leaves a two-stage pipeline and appears exactly two clock cycles after its request. One result comes out for each request.

Top module: `usb_btc_top`

## Requirements
- R1: Full speed (speed code 0) without split costs overhead + floor(mps*7/6) + 18. The overhead is 14 for non-isochronous, 10 for isochronous OUT (dir_in_i=0) and 11 for isochronous IN (dir_in_i=1).
- R2: Low speed (speed code 1), non-isochronous, without split costs 97 + 1 + 8*floor(mps*7/6) + 18.
- R3: The stuffing term truncates toward zero. The arithmetic never overflows for any packet size up to 1024, and every result is at most 9668.
- R4: High speed (speed code 2) without split costs (overhead + floor(mps*7/6) + 18) * xact_cnt_i. The overhead is 55 for non-isochronous and 38 for isochronous.
- R5: A split request (split_i=1) for a full- or low-speed device costs the high-speed overhead (55 or 38) + 18 + 4. The unscaled stuffing term is added to the complete phase (split_phase_i=1) when dir_in_i=1, and to the start phase (split_phase_i=0) when dir_in_i=0.
- R6: The following requests set err_o with bytes_o=0: speed code 3, a split request for a high-speed device, low-speed isochronous without split, high-speed non-split with xact_cnt_i=0, and mps_i above 1024.
- R7: res_valid_o is high exactly two cycles after each cycle in which req_valid_i is high, and low otherwise. It is low after reset.
- R8: xact_cnt_i has no effect on the result except for high-speed non-split requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| speed_i | input | 2 | 0 full, 1 low, 2 high, 3 reserved |
| iso_i | input | 1 | Isochronous transfer |
| dir_in_i | input | 1 | 1 device-to-host, 0 host-to-device |
| split_i | input | 1 | Cost one phase of a split transaction |
| split_phase_i | input | 1 | 0 start split, 1 complete split |
| mps_i | input | 11 | Maximum packet size in bytes |
| xact_cnt_i | input | 2 | Transactions per microframe |
| res_valid_o | output | 1 | Result strobe |
| bytes_o | output | 16 | Bus-time estimate in bytes |
| err_o | output | 1 | Request was invalid |

## Verification
The bench targets sizes where mps*7 lands just below and just above a multiple of six. A design that rounded up, or divided before multiplying, gives counts that are off by one there. It runs the four split cases of phase and direction, because a swapped rule moves the payload term onto the wrong phase and changes both totals. It also runs 1024-byte low-speed and three-transaction high-speed packets, where a narrow datapath wraps. Each invalid combination is checked to give zero with the flag set, and xact_cnt_i is varied on requests that must ignore it, so a multiplier applied too broadly shows up as a changed total.

// File: rtl/usb_btc_pkg.sv
package usb_btc_pkg;
  typedef enum logic [1:0] {
    SPD_FULL = 2'd0,
    SPD_LOW  = 2'd1,
    SPD_HIGH = 2'd2,
    SPD_RSVD = 2'd3
  } speed_e;

  localparam int unsigned FS_OVH_NONISO = 14;
  localparam int unsigned FS_OVH_ISO_OUT = 10;
  localparam int unsigned FS_OVH_ISO_IN = 11;
  localparam int unsigned LS_OVH = 97;
  localparam int unsigned LS_HUB_SETUP = 1;
  localparam int unsigned LS_SCALE_SH = 3;
  localparam int unsigned HS_OVH_NONISO = 55;
  localparam int unsigned HS_OVH_ISO = 38;
  localparam int unsigned SPLIT_OVH = 4;
  localparam int unsigned HOST_DELAY = 18;
  localparam int unsigned STUFF_NUM = 7;
  localparam int unsigned STUFF_DEN = 6;
endpackage

// File: rtl/usb_btc_overhead.sv
module usb_btc_overhead
  import usb_btc_pkg::*;
#(
  parameter int unsigned MPS_W   = 11,
  parameter int unsigned MAX_MPS = 1024,
  parameter int unsigned XACT_W  = 2,
  parameter int unsigned BASE_W  = 8
) (
  input  logic [1:0]        speed_i,
  input  logic              iso_i,
  input  logic              dir_in_i,
  input  logic              split_i,
  input  logic              split_phase_i,
  input  logic [MPS_W-1:0]  mps_i,
  input  logic [XACT_W-1:0] xact_cnt_i,
  output logic [BASE_W-1:0] base_o,
  output logic              use_pay_o,
  output logic              ls_scale_o,
  output logic [XACT_W-1:0] mult_o,
  output logic              err_o
);
  speed_e spd;
  logic   hs_ovh_sel;
  logic [BASE_W-1:0] hs_ovh;

  assign spd    = speed_e'(speed_i);
  assign hs_ovh = BASE_W'(iso_i ? HS_OVH_ISO : HS_OVH_NONISO);

  always_comb begin
    base_o     = '0;
    use_pay_o  = 1'b1;
    ls_scale_o = 1'b0;
    mult_o     = XACT_W'(1);
    err_o      = 1'b0;
    hs_ovh_sel = 1'b0;
    if (split_i) begin
      // split cost is high-speed bus time for a full/low-speed device
      hs_ovh_sel = 1'b1;
      base_o     = hs_ovh + BASE_W'(HOST_DELAY + SPLIT_OVH);
      use_pay_o  = (dir_in_i == split_phase_i);
      if (spd == SPD_HIGH || spd == SPD_RSVD) err_o = 1'b1;
    end else begin
      unique case (spd)
        SPD_FULL: begin
          if (!iso_i)       base_o = BASE_W'(FS_OVH_NONISO + HOST_DELAY);
          else if (dir_in_i) base_o = BASE_W'(FS_OVH_ISO_IN + HOST_DELAY);
          else              base_o = BASE_W'(FS_OVH_ISO_OUT + HOST_DELAY);
        end
        SPD_LOW: begin
          base_o     = BASE_W'(LS_OVH + LS_HUB_SETUP + HOST_DELAY);
          ls_scale_o = 1'b1;
          if (iso_i) err_o = 1'b1;
        end
        SPD_HIGH: begin
          hs_ovh_sel = 1'b1;
          base_o     = hs_ovh + BASE_W'(HOST_DELAY);
          mult_o     = xact_cnt_i;
          if (xact_cnt_i == '0) err_o = 1'b1;
        end
        default: err_o = 1'b1;
      endcase
    end
    if (mps_i > MPS_W'(MAX_MPS)) err_o = 1'b1;
  end
endmodule

// File: rtl/usb_btc_payload.sv
module usb_btc_payload
  import usb_btc_pkg::*;
#(
  parameter int unsigned MPS_W = 11,
  parameter int unsigned PAY_W = 16
) (
  input  logic [MPS_W-1:0] mps_i,
  input  logic             use_pay_i,
  input  logic             ls_scale_i,
  output logic [PAY_W-1:0] pay_o
);
  logic [PAY_W-1:0] prod;
  logic [PAY_W-1:0] stuffed;

  assign prod    = PAY_W'(mps_i) * PAY_W'(STUFF_NUM);
  assign stuffed = prod / PAY_W'(STUFF_DEN);
  assign pay_o   = !use_pay_i ? '0 :
                   ls_scale_i ? (stuffed << LS_SCALE_SH) : stuffed;
endmodule

// File: rtl/usb_btc_top.sv
module usb_btc_top
  import usb_btc_pkg::*;
#(
  parameter int unsigned MPS_W   = 11,
  parameter int unsigned MAX_MPS = 1024,
  parameter int unsigned XACT_W  = 2,
  parameter int unsigned BYTES_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         speed_i,
  input  logic               iso_i,
  input  logic               dir_in_i,
  input  logic               split_i,
  input  logic               split_phase_i,
  input  logic [MPS_W-1:0]   mps_i,
  input  logic [XACT_W-1:0]  xact_cnt_i,
  output logic               res_valid_o,
  output logic [BYTES_W-1:0] bytes_o,
  output logic               err_o
);
  localparam int unsigned BASE_W = 8;

  logic [BASE_W-1:0]  base_c;
  logic               use_pay_c, ls_scale_c, err_c;
  logic [XACT_W-1:0]  mult_c;
  logic [BYTES_W-1:0] pay_c;

  logic               s1_v, s1_err;
  logic [BYTES_W-1:0] s1_sum;
  logic [XACT_W-1:0]  s1_mult;

  usb_btc_overhead #(
    .MPS_W(MPS_W), .MAX_MPS(MAX_MPS), .XACT_W(XACT_W), .BASE_W(BASE_W)
  ) u_ovh (
    .speed_i(speed_i), .iso_i(iso_i), .dir_in_i(dir_in_i),
    .split_i(split_i), .split_phase_i(split_phase_i),
    .mps_i(mps_i), .xact_cnt_i(xact_cnt_i),
    .base_o(base_c), .use_pay_o(use_pay_c), .ls_scale_o(ls_scale_c),
    .mult_o(mult_c), .err_o(err_c)
  );

  usb_btc_payload #(.MPS_W(MPS_W), .PAY_W(BYTES_W)) u_pay (
    .mps_i(mps_i), .use_pay_i(use_pay_c), .ls_scale_i(ls_scale_c),
    .pay_o(pay_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s1_err  <= 1'b0;
      s1_sum  <= '0;
      s1_mult <= '0;
    end else begin
      s1_v <= req_valid_i;
      if (req_valid_i) begin
        s1_err  <= err_c;
        s1_sum  <= pay_c + BYTES_W'(base_c);
        s1_mult <= mult_c;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      err_o       <= 1'b0;
      bytes_o     <= '0;
    end else begin
      res_valid_o <= s1_v;
      if (s1_v) begin
        err_o   <= s1_err;
        bytes_o <= s1_err ? '0 : BYTES_W'(s1_sum * BYTES_W'(s1_mult));
      end
    end
  end
endmodule

// File: rtl/usb_btc_checker.sv
module usb_btc_checker #(
  parameter int unsigned MPS_W   = 11,
  parameter int unsigned XACT_W  = 2,
  parameter int unsigned BYTES_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [1:0]         speed_i,
  input logic               iso_i,
  input logic               split_i,
  input logic [MPS_W-1:0]   mps_i,
  input logic               res_valid_o,
  input logic [BYTES_W-1:0] bytes_o,
  input logic               err_o
);
  p_lat_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ##1 res_valid_o);
  p_lat_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ##1 !res_valid_o);
  p_err_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && err_o) |-> (bytes_o == '0));
  p_hs_split_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && split_i && speed_i == 2'd2) |=> ##1 err_o);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (bytes_o <= BYTES_W'(9668)));
  p_fs_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && speed_i == 2'd0 && !iso_i && !split_i && mps_i == '0)
    |=> ##1 (!err_o && bytes_o == BYTES_W'(32)));
endmodule

bind usb_btc_top usb_btc_checker #(
  .MPS_W(MPS_W), .XACT_W(XACT_W), .BYTES_W(BYTES_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .speed_i(speed_i), .iso_i(iso_i), .split_i(split_i), .mps_i(mps_i),
  .res_valid_o(res_valid_o), .bytes_o(bytes_o), .err_o(err_o)
);

// File: tb/usb_btc_top_bench.sv
module usb_btc_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_v = 1'b0;
  logic [1:0]  spd = '0;
  logic        iso = 1'b0, din = 1'b0, spl = 1'b0, ph = 1'b0;
  logic [10:0] mps = '0;
  logic [1:0]  xc = '0;
  logic        res_v, err;
  logic [15:0] bytes;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int due; int exp_b; bit exp_e; string tag; } exp_t;
  exp_t q[$];

  usb_btc_top u_usb_btc_top (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .speed_i(spd),
    .iso_i(iso), .dir_in_i(din), .split_i(spl), .split_phase_i(ph),
    .mps_i(mps), .xact_cnt_i(xc),
    .res_valid_o(res_v), .bytes_o(bytes), .err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void model(input int s, input bit is, input bit di,
      input bit sp, input bit p, input int m, input int n,
      output int b, output bit e);
    int st;
    st = (m * 7) / 6;
    e = 0; b = 0;
    if (s == 3 || m > 1024) e = 1;
    else if (sp) begin
      if (s == 2) e = 1;
      else b = (is ? 38 : 55) + 18 + 4 + ((di == p) ? st : 0);
    end else if (s == 0) b = (!is ? 14 : (di ? 11 : 10)) + st + 18;
    else if (s == 1) begin
      if (is) e = 1; else b = 97 + 1 + 8 * st + 18;
    end else begin
      if (n == 0) e = 1; else b = ((is ? 38 : 55) + st + 18) * n;
    end
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // called at negedge: compare outputs, then drive next request
  task automatic step(input bit v, input int s, input bit is, input bit di,
      input bit sp, input bit p, input int m, input int n, input string tag);
    exp_t x;
    bit want;
    want = (q.size() > 0) && (q[0].due == cyc);
    chk("R7 valid", res_v, want);
    if (want) begin
      x = q.pop_front();
      chk({x.tag, " bytes"}, bytes, x.exp_b);
      chk({x.tag, " err"}, err, x.exp_e);
    end
    req_v = v; spd = 2'(s); iso = is; din = di; spl = sp; ph = p;
    mps = 11'(m); xc = 2'(n);
    if (v) begin
      x.due = cyc + 2; x.tag = tag;
      model(s, is, di, sp, p, m, n, x.exp_b, x.exp_e);
      q.push_back(x);
    end
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R7 reset valid", res_v, 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0, 64, 1, "R1");
    step(1, 0, 1, 0, 0, 0, 6, 0, "R1");
    step(1, 0, 1, 1, 0, 0, 5, 3, "R1");
    step(1, 1, 0, 1, 0, 0, 8, 2, "R2");
    step(1, 1, 0, 0, 0, 0, 1024, 0, "R3");
    step(1, 0, 0, 0, 0, 0, 1, 1, "R3");
    step(1, 0, 0, 0, 0, 0, 11, 1, "R3");
    step(1, 2, 0, 1, 0, 0, 1024, 3, "R4");
    step(1, 2, 1, 0, 0, 0, 512, 2, "R4");
    step(1, 0, 0, 1, 1, 1, 64, 0, "R5");
    step(1, 0, 0, 1, 1, 0, 64, 0, "R5");
    step(1, 1, 1, 0, 1, 0, 64, 0, "R5");
    step(1, 1, 1, 0, 1, 1, 64, 0, "R5");
    step(1, 3, 0, 0, 0, 0, 64, 1, "R6");
    step(1, 2, 0, 0, 1, 0, 64, 1, "R6");
    step(1, 1, 1, 0, 0, 0, 8, 1, "R6");
    step(1, 2, 0, 0, 0, 0, 64, 0, "R6");
    step(1, 0, 0, 0, 0, 0, 1025, 1, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 0, 0, 0, 0, 0, 100, 0, "R8");
    step(1, 0, 0, 0, 0, 0, 100, 3, "R8");
    step(1, 1, 0, 0, 1, 0, 100, 2, "R8");
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, $urandom % 4, $urandom % 2, $urandom % 2,
           $urandom % 2, $urandom % 2, $urandom % 1100, $urandom % 4, "R1-mix");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    chk("R7 drained", q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule